// File: doc/BRIEF.md
# Tap Delay Line

The block keeps the last DEPTH words of a sample stream in a circular store and returns one of them on its output. A word is captured only on a clock edge where both the write strobe and the clock enable are high, so the delay counts strobed writes, not clock cycles. A run-time tap selects which word is returned: tap 0 is the newest word, and tap k is the word captured k strobes before the newest.

Slots that no write has reached since reset read back as a fixed fill word set by a parameter. The store contents are never cleared. Instead, a fill counter records how many valid words exist, and any tap at or beyond that count returns the fill word.

A parameter fixes the tap at the oldest slot for a plain static delay. A second parameter adds one output pipeline stage. Any depth of two or more is supported, including depths that are not a power of two.

Top module: `tap_delay_line`

## Requirements
- R1: A word is stored only on a rising clock edge where en_i and stb_i are both 1. Any other edge leaves the stored words, the write position and the fill count unchanged.
- R2: With n valid words stored and DYN_EN=1, delay_i=k with k<n returns the word stored k strobes before the newest. Tap 0 is the newest word.
- R3: After reset, a tap k with k greater than or equal to the number of words stored since reset returns DEF_WORD.
- R4: Once DEPTH words are stored, each new write discards the oldest one. Taps 0..DEPTH-1 always refer to the last DEPTH writes, across the wrap of the write position for any depth.
- R5: A change on delay_i reaches data_o after one rising edge when OUT_REG=0, and after two rising edges when OUT_REG=1. With OUT_REG=1, the output after the first edge still reflects the previous tap.
- R6: While en_i is 0, data_o holds its value whatever delay_i, stb_i and data_i do.
- R7: A delay_i value of DEPTH or more, which the tap width permits when DEPTH is not a power of two, returns DEF_WORD.
- R8: With DYN_EN=0, delay_i is ignored and the tap is fixed at DEPTH-1.
- R9: Asserting rst_ni low mid-stream empties the line. data_o reads DEF_WORD, and every tap returns DEF_WORD until new words are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for writes and output registers |
| stb_i | input | 1 | Write strobe; captures data_i when en_i is 1 |
| data_i | input | DATA_W | Word to store |
| delay_i | input | DLY_W = $clog2(DEPTH) | Tap select: 0 is the newest word |
| data_o | output | DATA_W | Selected word, or DEF_WORD |

## Verification
The bench builds three instances that share one stimulus:
- depth 5 with no output stage;
- depth 6 with the output stage;
- depth 4 with the tap fixed by parameter.

Depths 5 and 6 are not powers of two. Their 3-bit tap lets the codes past the last slot be driven, and each write-position wrap arrives within a few strobes. Every tap is swept after every write, through fill-up and more than two full wraps. The expected words come from a history list kept in the bench, and the two dynamic instances give both latencies side by side.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  // Position `back` entries behind `ptr` in a ring of `depth` slots.
  function automatic int ring_back(int ptr, int back, int depth);
    if (ptr >= back) return ptr - back;
    return ptr + depth - back;
  endfunction
endpackage

// File: rtl/tdl_wr_ctrl.sv
module tdl_wr_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [CNT_W-1:0] fill_o
);
  logic [PTR_W-1:0] wr_ptr_q;
  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      fill_q   <= '0;
    end else if (we_i) begin
      wr_ptr_q <= (int'(wr_ptr_q) == DEPTH - 1) ? '0 : wr_ptr_q + PTR_W'(1);
      if (int'(fill_q) < DEPTH) fill_q <= fill_q + CNT_W'(1);
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign fill_o   = fill_q;

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(wr_ptr_q) && $stable(fill_q)));
  // R4
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_ptr_q) < DEPTH);
  // R4
  fill_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill_q) <= DEPTH);
endmodule

// File: rtl/tdl_store.sv
module tdl_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && int'(wr_addr_i) < DEPTH) mem_q[wr_addr_i] <= wr_data_i;
  end

  // Out-of-range addresses only occur when the tap misses; the data is discarded then.
  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) < DEPTH) rd_data_o = mem_q[rd_addr_i];
  end
endmodule

// File: rtl/tdl_tap_sel.sv
module tdl_tap_sel #(
  parameter int              DATA_W   = 32,
  parameter int              DEPTH    = 16,
  parameter bit              DYN_EN   = 1'b1,
  parameter logic [DATA_W-1:0] DEF_WORD = '0,
  parameter bit              OUT_REG  = 1'b0,
  parameter int              DLY_W    = 4,
  parameter int              PTR_W    = 4,
  parameter int              CNT_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [CNT_W-1:0]  fill_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DLY_W-1:0]  tap;
  logic              hit;
  logic [DATA_W-1:0] stage1_q;

  if (DYN_EN) begin : g_dyn
    assign tap = delay_i;
  end else begin : g_fix
    assign tap = DLY_W'(DEPTH - 1);
  end

  assign hit       = int'(tap) < int'(fill_i);
  assign rd_addr_o = PTR_W'(tdl_pkg::ring_back(int'(wr_ptr_i), int'(tap) + 1, DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stage1_q <= DEF_WORD;
    else if (en_i) stage1_q <= hit ? rd_data_i : DEF_WORD;
  end

  if (OUT_REG) begin : g_oreg
    logic [DATA_W-1:0] stage2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   stage2_q <= DEF_WORD;
      else if (en_i) stage2_q <= stage1_q;
    end
    assign data_o = stage2_q;
  end else begin : g_noreg
    assign data_o = stage1_q;
  end

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_o));
  // R3
  empty_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fill_i == '0) |=> stage1_q == DEF_WORD);
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
  parameter int                DATA_W   = 32,
  parameter int                DEPTH    = 16,
  parameter bit                DYN_EN   = 1'b1,
  parameter logic [DATA_W-1:0] DEF_WORD = 32'hDEADBEEF,
  parameter bit                OUT_REG  = 1'b0,
  localparam int               DLY_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int PTR_W = DLY_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              we;
  logic [PTR_W-1:0]  wr_ptr;
  logic [CNT_W-1:0]  fill;
  logic [PTR_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;

  assign we = en_i & stb_i;

  tdl_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_wr_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wr_ptr_o(wr_ptr),
    .fill_o  (fill)
  );

  tdl_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i    (clk_i),
    .we_i     (we),
    .wr_addr_i(wr_ptr),
    .wr_data_i(data_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  tdl_tap_sel #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .DYN_EN(DYN_EN), .DEF_WORD(DEF_WORD),
    .OUT_REG(OUT_REG), .DLY_W(DLY_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_tap_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .delay_i  (delay_i),
    .wr_ptr_i (wr_ptr),
    .fill_i   (fill),
    .rd_addr_o(rd_addr),
    .rd_data_i(rd_data),
    .data_o   (data_o)
  );
endmodule

// File: tb/tap_delay_line_bench.sv
module tap_delay_line_bench;
  localparam logic [31:0] DEF = 32'hDEADBEEF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        stb_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [2:0]  delay_i = '0;
  logic [31:0] out5, out6, out4;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] hist [64];
  int cnt = 0;

  always #4 clk_i = ~clk_i;

  // depth 5, no output stage
  tap_delay_line #(.DATA_W(32), .DEPTH(5), .DYN_EN(1'b1), .DEF_WORD(DEF), .OUT_REG(1'b0)) u_tap_delay_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .stb_i(stb_i),
    .data_i(data_i), .delay_i(delay_i), .data_o(out5));
  // depth 6, output stage
  tap_delay_line #(.DATA_W(32), .DEPTH(6), .DYN_EN(1'b1), .DEF_WORD(DEF), .OUT_REG(1'b1)) u_tap_delay_line_oreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .stb_i(stb_i),
    .data_i(data_i), .delay_i(delay_i), .data_o(out6));
  // depth 4, fixed tap
  tap_delay_line #(.DATA_W(32), .DEPTH(4), .DYN_EN(1'b0), .DEF_WORD(DEF), .OUT_REG(1'b0)) u_tap_delay_line_fix (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .stb_i(stb_i),
    .data_i(data_i), .delay_i(delay_i[1:0]), .data_o(out4));

  function automatic logic [31:0] expv(int tap, int depth);
    if (tap < cnt && tap < depth) return hist[cnt-1-tap];
    return DEF;
  endfunction

  function automatic string auto_tag(int tap, int depth);
    if (tap >= depth) return "R7";
    if (tap >= cnt)   return "R3";
    if (cnt > depth)  return "R4";
    return "R2";
  endfunction

  task automatic chk(logic [31:0] got, logic [31:0] exp, string req, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, got, exp);
    end
  endtask

  task automatic push(logic [31:0] w);
    data_i = w;
    stb_i  = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    stb_i = 1'b0;
    hist[cnt] = w;
    cnt++;
  endtask

  // Starts and ends at a falling edge.
  task automatic probe(int j, bit lag, string tag);
    delay_i = 3'(j);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(out5, expv(j, 5), (tag == "") ? auto_tag(j, 5) : tag, "depth5 tap");
    // R5: the staged instance still shows the previous tap after one edge
    if (lag) chk(out6, expv(j - 1, 6), "R5", "depth6 lag");
    @(posedge clk_i);
    @(negedge clk_i);
    chk(out6, expv(j, 6), (tag == "") ? auto_tag(j, 6) : tag, "depth6 tap");
    // R8: fixed tap at the oldest slot
    chk(out4, expv(3, 4), (tag == "") ? "R8" : tag, "depth4 fixed");
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] h5, h6, h4;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3: reset state
    chk(out5, DEF, "R3", "reset depth5");
    chk(out6, DEF, "R3", "reset depth6");
    chk(out4, DEF, "R3", "reset depth4");
    for (int j = 0; j < 8; j++) probe(j, j > 0, "R3");

    // R2 R4 R7 R8: sweep every tap through fill-up and wrap
    for (int n = 0; n < 14; n++) begin
      push(32'hA5000000 + 32'(n * 32'h1011));
      for (int j = 0; j < 8; j++) probe(j, j > 0, "");
    end

    // R6: enable low holds the output; R1: no write without enable
    probe(2, 1'b0, "");
    h5 = out5; h6 = out6; h4 = out4;
    en_i = 1'b0; stb_i = 1'b1; data_i = 32'h0BADF00D; delay_i = 3'd5;
    repeat (3) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk(out5, h5, "R6", "hold depth5");
      chk(out6, h6, "R6", "hold depth6");
      chk(out4, h4, "R6", "hold depth4");
    end
    en_i = 1'b1; stb_i = 1'b0;
    repeat (3) @(negedge clk_i);
    for (int j = 0; j < 8; j++) probe(j, j > 0, "R1");

    // R9: reset mid-stream empties the line
    rst_ni = 1'b0;
    #1;
    chk(out5, DEF, "R9", "async reset depth5");
    chk(out6, DEF, "R9", "async reset depth6");
    @(negedge clk_i);
    rst_ni = 1'b1;
    cnt = 0;
    for (int j = 0; j < 8; j++) probe(j, j > 0, "R9");
    push(32'h11112222);
    push(32'h33334444);
    for (int j = 0; j < 8; j++) probe(j, j > 0, "");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule